// File: doc/BRIEF.md
# Parallel-Lane Waveform Playback Engine

This block feeds a wide serializer that in turn drives a fast digital-to-analog converter. Each fabric clock it emits one output word of sixteen samples. It reads them from sixteen identical copies of a waveform table, and each copy is addressed at its own offset from one shared base. The table copies are loaded through a single write port that writes every copy at once. That port works only while the block is idle.

The block has two playback modes, chosen when generation starts. Arbitrary mode plays a stored pattern from a start address to an inclusive stop address, then loops back. DDS mode runs a 32-bit phase accumulator. Each lane takes the top table-address bits of its own phase point, so the tuning word sets the output frequency. In DDS mode an optional sweep raises the tuning word by a fixed step at a fixed clock interval, and stops at a ceiling. Generation starts either at once or, in sync mode, on the first external trigger after arming. A stop command ends it.

The output is a valid/ready stream:
- The block offers a word by raising `out_valid`.
- The word counts as taken on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the word and `out_valid` stay unchanged, and no sample is lost or skipped.
- The one exception is a stop command, which withdraws any pending word.

Top module: `wave_lane_player`

## Requirements
- R1: A write (`wr_en` high) that is sampled while the block is idle stores `wr_data` at `wr_addr` in every lane copy. A write that is sampled while the block is armed or running has no effect on any copy.
- R2: In arbitrary mode (`mode_dds`=0 at start), output word n holds, in lane k, the table entry at address b(n)+k, where lane k occupies bits [14k+13:14k] and lane 0 is the earliest sample. The base b starts at `start_addr`. After each word it goes up by 16, except after a word whose lane-15 address is at or beyond `stop_addr`, when it returns to `start_addr`.
- R3: In DDS mode (`mode_dds`=1 at start), the accumulator A starts at 0 and goes up by 16 times the increment for every word taken. Lane k reads address bits [31:25] of A+k×increment, taken modulo 2^32. Without sweep, the increment is `tune_word`.
- R4: With `sweep_en`=1 in DDS mode, word j (j=0 first) uses increment min(`tune_word` + floor(j/P)×`sweep_step`, `sweep_max`), where P is `sweep_period`, and a period of 0 acts as 1. All mode, address, tuning and sweep settings are captured on the start cycle.
- R5: With `sync_en`=0, a `start_req` sampled while idle starts generation. `out_valid` is low after that edge and the first word is valid after the next edge.
- R6: With `sync_en`=1, a start arms the block and `out_valid` stays low until `trig_in` is sampled high. The first word is valid one edge after that trigger edge.
- R7: `stop_req` returns the block to idle and `out_valid` is low after the edge where it is sampled. When it is sampled together with `start_req`, the stop wins.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. The word offered after the stall ends is the next word in sequence.
- R9: After reset the block is idle with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Table write address |
| wr_data | input | 14 | Table write sample |
| mode_dds | input | 1 | 0 arbitrary, 1 DDS |
| start_addr | input | 7 | First address of the stored pattern |
| stop_addr | input | 7 | Last address of the stored pattern (inclusive) |
| tune_word | input | 32 | DDS increment, initial sweep value |
| sweep_en | input | 1 | Enable increment sweep in DDS mode |
| sweep_step | input | 32 | Amount added to the increment per sweep update |
| sweep_max | input | 32 | Increment ceiling |
| sweep_period | input | 8 | Clocks between sweep updates |
| sync_en | input | 1 | Wait for trigger after start |
| trig_in | input | 1 | External trigger |
| start_req | input | 1 | Start command |
| stop_req | input | 1 | Stop command |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 224 | Sixteen 14-bit samples, lane 0 in the low bits |

## Verification
The bench targets these failure cases:
- **Pattern wrap.** It runs windows of one, two and eight words. A wrap check that is off by one would play a word past the stop address, or cut the loop a word short.
- **DDS phase.** The DDS patterns are chosen so that a lane offset missing its k×increment term, or an accumulator step that is not sixteen increments, changes the lane addresses in the very first words.
- **Sweep.** It runs the sweep into saturation. Updating one clock early or late, or wrapping instead of clamping, gives wrong addresses from the affected word onward.
- **Stream and control.** It stalls the stream, blocks writes during playback, holds output until the trigger in sync mode, and issues start and stop together. A design that skipped a word, let a write through, started before the trigger or let the start win would fail there.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } play_state_e;
endpackage

// File: rtl/wlp_ctrl.sv
module wlp_ctrl
  import wlp_pkg::*;
#(
  parameter int PW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          sync_en,
  input  logic          trig_in,
  input  logic          mode_dds,
  input  logic          sweep_en,
  input  logic [PW-1:0] tune_word,
  input  logic [PW-1:0] sweep_step,
  input  logic [PW-1:0] sweep_max,
  input  logic [CW-1:0] sweep_period,
  output play_state_e   state,
  output logic          load,
  output logic          dds_q,
  output logic [PW-1:0] inc_q
);
  logic          sweep_q;
  logic [PW-1:0] step_q, max_q;
  logic [CW-1:0] per_q, cnt_q;
  logic [PW:0]   bumped;
  logic          tick;

  assign load   = (state == ST_IDLE) && start_req && !stop_req;
  assign bumped = {1'b0, inc_q} + {1'b0, step_q};
  assign tick   = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, per_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (stop_req) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (start_req) state <= sync_en ? ST_ARMED : ST_RUN;
        ST_ARMED: if (trig_in) state <= ST_RUN;
        default:  state <= state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dds_q   <= 1'b0;
      sweep_q <= 1'b0;
      inc_q   <= '0;
      step_q  <= '0;
      max_q   <= '0;
      per_q   <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      dds_q   <= mode_dds;
      sweep_q <= sweep_en && mode_dds;
      inc_q   <= tune_word;
      step_q  <= sweep_step;
      max_q   <= sweep_max;
      per_q   <= sweep_period;
      cnt_q   <= '0;
    end else if (state == ST_RUN && sweep_q) begin
      if (tick) begin
        cnt_q <= '0;
        if (bumped > {1'b0, max_q}) inc_q <= max_q;
        else                        inc_q <= bumped[PW-1:0];
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/wlp_addr_gen.sv
module wlp_addr_gen #(
  parameter int LANES = 16,
  parameter int AW    = 7,
  parameter int PW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              dds,
  input  logic [AW-1:0]     start_addr,
  input  logic [AW-1:0]     stop_addr,
  input  logic [PW-1:0]     inc,
  output logic [LANES*AW-1:0] lane_addr
);
  logic [AW-1:0] base_q, start_q, stop_q;
  logic [PW-1:0] acc_q;
  logic          last_word;

  assign last_word = ({1'b0, base_q} + (AW+1)'(LANES-1)) >= {1'b0, stop_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
      acc_q   <= '0;
    end else if (load) begin
      base_q  <= start_addr;
      start_q <= start_addr;
      stop_q  <= stop_addr;
      acc_q   <= '0;
    end else if (adv) begin
      if (dds) acc_q <= acc_q + inc * PW'(LANES);
      else     base_q <= last_word ? start_q : base_q + AW'(LANES);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PW-1:0] ph;
    assign ph = acc_q + inc * PW'(k);
    assign lane_addr[k*AW +: AW] = dds ? ph[PW-1 -: AW] : base_q + AW'(k);
  end
endmodule

// File: rtl/wlp_lane_ram.sv
module wlp_lane_ram #(
  parameter int AW = 7,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wave_lane_player.sv
module wave_lane_player
  import wlp_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 7,
  parameter int DW    = 14,
  parameter int PW    = 32,
  parameter int CW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               mode_dds,
  input  logic [AW-1:0]      start_addr,
  input  logic [AW-1:0]      stop_addr,
  input  logic [PW-1:0]      tune_word,
  input  logic               sweep_en,
  input  logic [PW-1:0]      sweep_step,
  input  logic [PW-1:0]      sweep_max,
  input  logic [CW-1:0]      sweep_period,
  input  logic               sync_en,
  input  logic               trig_in,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [LANES*DW-1:0] out_data
);
  play_state_e        st_q;
  logic               load, dds_q, adv, wr_ok;
  logic [PW-1:0]      inc_q;
  logic [LANES*AW-1:0] lane_addr;

  assign adv   = (st_q == ST_RUN) && (!out_valid || out_ready);
  assign wr_ok = wr_en && (st_q == ST_IDLE);

  wlp_ctrl #(.PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .sync_en(sync_en), .trig_in(trig_in), .mode_dds(mode_dds),
    .sweep_en(sweep_en), .tune_word(tune_word), .sweep_step(sweep_step),
    .sweep_max(sweep_max), .sweep_period(sweep_period),
    .state(st_q), .load(load), .dds_q(dds_q), .inc_q(inc_q)
  );

  wlp_addr_gen #(.LANES(LANES), .AW(AW), .PW(PW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .dds(dds_q),
    .start_addr(start_addr), .stop_addr(stop_addr), .inc(inc_q),
    .lane_addr(lane_addr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_ram
    wlp_lane_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk(clk), .we(wr_ok), .waddr(wr_addr), .wdata(wr_data),
      .re(adv), .raddr(lane_addr[k*AW +: AW]), .rdata(out_data[k*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        out_valid <= 1'b0;
    else if (stop_req || st_q != ST_RUN) out_valid <= 1'b0;
    else if (adv)                      out_valid <= 1'b1;
  end
endmodule

// File: rtl/wlp_checker.sv
module wlp_checker
  import wlp_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_req,
  input logic               stop_req,
  input logic               sync_en,
  input logic               out_ready,
  input logic               out_valid,
  input logic [LANES*DW-1:0] out_data,
  input play_state_e        st
);
  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R5
  start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_req && !stop_req && !sync_en)
      |=> !out_valid ##1 (out_valid || $past(stop_req)));

  // R6
  armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED) |=> !out_valid);

  // R7
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !stop_req) |=> (out_valid && $stable(out_data)));
endmodule

bind wave_lane_player wlp_checker #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
  .sync_en(sync_en), .out_ready(out_ready), .out_valid(out_valid),
  .out_data(out_data), .st(st_q)
);

// File: tb/wave_lane_player_test.sv
module wave_lane_player_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16, AW = 7, DW = 14, PW = 32, CW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int OW = LANES * DW;

  typedef struct packed {
    logic        dds;
    logic [6:0]  sa;
    logic [6:0]  ea;
    logic [31:0] tune;
    logic [7:0]  nw;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 7'd0,  7'd127, 32'h0,         8'd10},
    '{1'b0, 7'd32, 7'd63,  32'h0,         8'd5},
    '{1'b0, 7'd96, 7'd111, 32'h0,         8'd3},
    '{1'b1, 7'd0,  7'd0,   32'h0100_0000, 8'd6},
    '{1'b1, 7'd0,  7'd0,   32'h1234_5678, 8'd6}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mode_dds = 0, sweep_en = 0, sync_en = 0, trig_in = 0;
  logic start_req = 0, stop_req = 0, out_ready = 1;
  logic [AW-1:0] wr_addr = '0, start_addr = '0, stop_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [PW-1:0] tune_word = '0, sweep_step = '0, sweep_max = '0;
  logic [CW-1:0] sweep_period = '0;
  logic out_valid;
  logic [OW-1:0] out_data;

  logic [DW-1:0] shadow [DEPTH];
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_lane_player #(.LANES(LANES), .AW(AW), .DW(DW), .PW(PW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_dds(mode_dds), .start_addr(start_addr), .stop_addr(stop_addr),
    .tune_word(tune_word), .sweep_en(sweep_en), .sweep_step(sweep_step),
    .sweep_max(sweep_max), .sweep_period(sweep_period), .sync_en(sync_en),
    .trig_in(trig_in), .start_req(start_req), .stop_req(stop_req),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] arb_word(input int b);
    logic [OW-1:0] w;
    for (int k = 0; k < LANES; k++) w[k*DW +: DW] = shadow[(b + k) % DEPTH];
    return w;
  endfunction

  function automatic logic [OW-1:0] dds_word(input logic [31:0] acc, input logic [31:0] inc);
    logic [OW-1:0] w;
    for (int k = 0; k < LANES; k++) begin
      logic [31:0] ph;
      ph = acc + inc * k;
      w[k*DW +: DW] = shadow[ph[31:25]];
    end
    return w;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d, input bit takes);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 0;
    if (takes) shadow[a] = d;
  endtask

  task automatic do_stop();
    stop_req = 1;
    tick();
    stop_req = 0;
    chk(out_valid == 1'b0, "R7 stop", OW'(out_valid), '0);
  endtask

  task automatic play(input bit dds, input int sa, input int ea, input logic [31:0] tune,
                      input bit sw, input logic [31:0] step, input logic [31:0] mx,
                      input int per, input int nw, input string req);
    int b;
    logic [31:0] acc;
    logic [31:0] inc;
    longint unsigned t;
    int p;
    mode_dds = dds; start_addr = AW'(sa); stop_addr = AW'(ea); tune_word = tune;
    sweep_en = sw; sweep_step = step; sweep_max = mx; sweep_period = CW'(per);
    sync_en = 0; out_ready = 1;
    start_req = 1;
    tick();
    start_req = 0;
    chk(out_valid == 1'b0, "R5 not yet valid", OW'(out_valid), '0);
    b = sa; acc = '0; p = (per == 0) ? 1 : per;
    for (int j = 0; j < nw; j++) begin
      logic [OW-1:0] e;
      tick();
      if (dds) begin
        inc = tune;
        if (sw) begin
          t = longint'(tune) + longint'(j / p) * longint'(step);
          inc = (t > longint'(mx)) ? mx : t[31:0];
        end
        e = dds_word(acc, inc);
        acc = acc + inc * 16;
      end else begin
        e = arb_word(b);
        b = (b + LANES - 1 >= ea) ? sa : b + LANES;
      end
      chk(out_valid && out_data == e, req, out_data, e);
    end
    do_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(out_valid == 1'b0, "R9 reset valid", OW'(out_valid), '0);

    // R1: load every table copy through the shared port while idle
    for (int a = 0; a < DEPTH; a++) write_word(a, DW'((a * 97 + 3) & 14'h3fff), 1'b1);

    // R2/R3: table of stimulus vectors
    foreach (VECS[i]) begin
      play(VECS[i].dds, int'(VECS[i].sa), int'(VECS[i].ea), VECS[i].tune,
           1'b0, 32'h0, 32'h0, 0, int'(VECS[i].nw), VECS[i].dds ? "R3 dds" : "R2 arb");
    end

    // R4: sweep into saturation, then period 0
    play(1'b1, 0, 0, 32'h0100_0000, 1'b1, 32'h0080_0000, 32'h0240_0000, 3, 12, "R4 sweep");
    play(1'b1, 0, 0, 32'h0040_0000, 1'b1, 32'h0100_0000, 32'h0500_0000, 0, 8, "R4 period0");

    // R1: idle write reaches all lanes
    write_word(5, 14'h1555, 1'b1);
    play(1'b0, 5, 20, 32'h0, 1'b0, 0, 0, 0, 2, "R1 idle write lane0");
    play(1'b0, 0, 15, 32'h0, 1'b0, 0, 0, 0, 1, "R1 idle write lane5");

    // R1: write while running is ignored
    mode_dds = 0; start_addr = 0; stop_addr = 15; sync_en = 0;
    start_req = 1; tick(); start_req = 0;
    tick();
    write_word(5, 14'h2aaa, 1'b0);
    do_stop();
    play(1'b0, 0, 15, 32'h0, 1'b0, 0, 0, 0, 2, "R1 busy write ignored");

    // R6: sync start waits for trigger
    mode_dds = 0; start_addr = 32; stop_addr = 63; sync_en = 1;
    start_req = 1; tick(); start_req = 0;
    repeat (4) tick();
    chk(out_valid == 1'b0, "R6 armed quiet", OW'(out_valid), '0);
    trig_in = 1; tick(); trig_in = 0;
    chk(out_valid == 1'b0, "R6 trigger edge", OW'(out_valid), '0);
    tick();
    chk(out_valid && out_data == arb_word(32), "R6 first word", out_data, arb_word(32));
    tick();
    chk(out_valid && out_data == arb_word(48), "R6 second word", out_data, arb_word(48));
    do_stop();
    sync_en = 0;

    // R8: back-pressure hold and no skip
    mode_dds = 0; start_addr = 0; stop_addr = 127;
    start_req = 1; tick(); start_req = 0;
    tick();
    chk(out_valid && out_data == arb_word(0), "R8 word0", out_data, arb_word(0));
    out_ready = 0;
    repeat (3) tick();
    chk(out_valid && out_data == arb_word(0), "R8 held", out_data, arb_word(0));
    out_ready = 1;
    tick();
    chk(out_valid && out_data == arb_word(16), "R8 next", out_data, arb_word(16));
    tick();
    chk(out_valid && out_data == arb_word(32), "R8 after", out_data, arb_word(32));
    do_stop();

    // R7: stop beats start
    start_req = 1; stop_req = 1; tick(); start_req = 0; stop_req = 0;
    repeat (3) tick();
    chk(out_valid == 1'b0, "R7 stop wins", OW'(out_valid), '0);

    // R9: reset mid-run
    start_req = 1; tick(); start_req = 0;
    tick();
    rst_n = 0; tick(); rst_n = 1;
    repeat (2) tick();
    chk(out_valid == 1'b0, "R9 reset mid-run", OW'(out_valid), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule